// File: doc/BRIEF.md
# Dual-Event Shadow Register Commit

This block keeps a bank of configuration registers for a display controller with two outputs: a panel path and a digital path. Each register has two copies. Software writes the shadow copy through a single-cycle write port. The rest of the chip sees only the active copy. Each register is mapped at build time to the panel path, to the digital path, or to both.

To apply new settings, software writes the control word and arms a commit flag for one output. While a flag is armed, the frame event of that output copies every shadow register mapped to the output into its active copy, all in the same clock edge. The same edge clears the flag, so software can poll it to see that the copy is done. A shared register is updated by whichever armed event arrives first. Both frame events arrive as single-cycle pulses: the start of the vertical front porch for the panel path and the external vertical sync for the digital path.

Top module: `sdc_shadow_commit`

## Requirements
- R1: On reset, the shadow and active copies of register i both hold ((i+1)*37) truncated to DATA_W bits, and both commit flags read 0.
- R2: A write to address i (0 to NUM_REGS-1) updates only the shadow copy. The active outputs do not change until a commit event selects that register.
- R3: The control word sits at address NUM_REGS. A write there with bit 5 set arms the panel flag, and a write with bit 6 set arms the digital flag. A 0 in either bit leaves that flag as it is. The flags appear on `panel_go` and `digital_go`.
- R4: A `panel_evt` pulse while the panel flag is armed copies, at that clock edge, every shadow register in PANEL_MAP (default: registers 0 to 4) into its active copy. All other registers keep their active values.
- R5: A `digital_evt` pulse while the digital flag is armed copies, at that clock edge, every shadow register in DIGITAL_MAP (default: registers 0, 1, 5, 6 and 7) into its active copy. All other registers keep their active values.
- R6: The edge that performs a commit clears that path's flag, so the flag reads 0 in the following cycle. If a write arms the same flag in that cycle, the clear takes priority.
- R7: A frame event that arrives while its flag is clear leaves every active value unchanged.
- R8: If a shadow write and a commit of that register fall in the same cycle, the value held before the write is committed. The new value stays in the shadow copy for a later commit.
- R9: If both armed events arrive in the same cycle, a shared register receives its current shadow value once. Each path's own registers are copied as in R4 and R5.
- R10: Writes to addresses above NUM_REGS change neither the shadow copies, the active copies nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | ADDR_W | Write address: shadow registers, then the control word |
| wr_data | input | DATA_W | Write data |
| panel_evt | input | 1 | Pulse at the start of the panel vertical front porch |
| digital_evt | input | 1 | Pulse at the external vertical sync of the digital path |
| active_flat | output | NUM_REGS*DATA_W | Active register values, register i in bits [i*DATA_W +: DATA_W] |
| panel_go | output | 1 | Panel commit flag status |
| digital_go | output | 1 | Digital commit flag status |

## Verification
The main sweep goes through every combination of armed flags and arriving events, with and without a shadow write in the event cycle. Arming without an event shows that staging and commit are kept apart. An event without an armed flag shows that R7 holds. A single armed event shows which registers belong to each map, and two armed events at once show how shared registers are merged. The write in the event cycle shows whether the value before or after the write is committed. Directed cases cover arming in the commit cycle and writes above the control address.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int PANEL_GO_BIT   = 5;
  localparam int DIGITAL_GO_BIT = 6;

  // Reset value of register idx, before truncation to the data width.
  function automatic logic [31:0] default_value(input int idx);
    return 32'((idx + 1) * 37);
  endfunction

  // A register is copied when an event on any path it belongs to commits.
  function automatic logic copy_hit(input logic on_panel, input logic on_digital,
                                    input logic panel_commit, input logic digital_commit);
    return (on_panel & panel_commit) | (on_digital & digital_commit);
  endfunction

  // Flag update: a commit clears the flag, an arming write sets it, and the clear wins.
  function automatic logic go_next(input logic go, input logic arm, input logic commit);
    return commit ? 1'b0 : (arm ? 1'b1 : go);
  endfunction
endpackage

// File: rtl/sdc_go_flag.sv
module sdc_go_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic frame_evt,
  output logic go,
  output logic commit
);
  assign commit = go & frame_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) go <= 1'b0;
    else        go <= sdc_pkg::go_next(go, arm, commit);
  end
endmodule

// File: rtl/sdc_reg_slot.sv
module sdc_reg_slot #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              copy,
  output logic [DATA_W-1:0] shadow,
  output logic [DATA_W-1:0] active
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= RESET_VAL;
      active <= RESET_VAL;
    end else begin
      if (wr_hit) shadow <= wr_data;
      if (copy)   active <= shadow;  // the value before a same-cycle write
    end
  end
endmodule

// File: rtl/sdc_shadow_commit.sv
module sdc_shadow_commit #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter logic [NUM_REGS-1:0] PANEL_MAP   = 8'h1F,
  parameter logic [NUM_REGS-1:0] DIGITAL_MAP = 8'hE3,
  localparam int ADDR_W    = $clog2(NUM_REGS + 1),
  localparam int CTRL_ADDR = NUM_REGS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       panel_evt,
  input  logic                       digital_evt,
  output logic [NUM_REGS*DATA_W-1:0] active_flat,
  output logic                       panel_go,
  output logic                       digital_go
);
  // Named internal events, brought out for the checker.
  logic                       ctrl_hit;
  logic                       panel_arm;
  logic                       digital_arm;
  logic                       panel_commit;
  logic                       digital_commit;
  logic [NUM_REGS-1:0]        copy_vec;
  logic [NUM_REGS*DATA_W-1:0] shadow_flat;

  assign ctrl_hit    = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign panel_arm   = ctrl_hit && wr_data[sdc_pkg::PANEL_GO_BIT];
  assign digital_arm = ctrl_hit && wr_data[sdc_pkg::DIGITAL_GO_BIT];

  sdc_go_flag u_panel_flag (
    .clk(clk), .rst_n(rst_n), .arm(panel_arm), .frame_evt(panel_evt),
    .go(panel_go), .commit(panel_commit)
  );

  sdc_go_flag u_digital_flag (
    .clk(clk), .rst_n(rst_n), .arm(digital_arm), .frame_evt(digital_evt),
    .go(digital_go), .commit(digital_commit)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic wr_hit;
    assign wr_hit      = wr_en && (wr_addr == ADDR_W'(i));
    assign copy_vec[i] = sdc_pkg::copy_hit(PANEL_MAP[i], DIGITAL_MAP[i],
                                           panel_commit, digital_commit);
    sdc_reg_slot #(
      .DATA_W(DATA_W),
      .RESET_VAL(DATA_W'(sdc_pkg::default_value(i)))
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_data(wr_data),
      .copy(copy_vec[i]),
      .shadow(shadow_flat[i*DATA_W +: DATA_W]),
      .active(active_flat[i*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/sdc_shadow_commit_checker.sv
module sdc_shadow_commit_checker #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter logic [NUM_REGS-1:0] PANEL_MAP   = 8'h1F,
  parameter logic [NUM_REGS-1:0] DIGITAL_MAP = 8'hE3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       panel_evt,
  input logic                       digital_evt,
  input logic                       panel_go,
  input logic                       digital_go,
  input logic                       panel_arm,
  input logic                       digital_arm,
  input logic                       panel_commit,
  input logic                       digital_commit,
  input logic [NUM_REGS*DATA_W-1:0] shadow_flat,
  input logic [NUM_REGS*DATA_W-1:0] active_flat
);
  // R2 / R7: no commit means no change in the active copies.
  assert_hold_without_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!panel_commit && !digital_commit) |=> $stable(active_flat));

  assert_idle_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_evt && !panel_go && digital_evt && !digital_go) |=> $stable(active_flat));

  // R3: arming without a commit leaves the flag set.
  assert_panel_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_arm && !panel_commit) |=> panel_go);
  assert_digital_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (digital_arm && !digital_commit) |=> digital_go);

  // R6: a commit clears its flag, even when it is armed again in the same cycle.
  assert_panel_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    panel_commit |=> !panel_go);
  assert_digital_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    digital_commit |=> !digital_go);
  assert_panel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_go && !panel_evt) |=> panel_go);

  // R4 / R5 / R8 / R9: a committed register takes the shadow value from before the edge.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_copy
    if (PANEL_MAP[i]) begin : g_p
      assert_panel_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        panel_commit |=> active_flat[i*DATA_W +: DATA_W] == $past(shadow_flat[i*DATA_W +: DATA_W]));
    end
    if (DIGITAL_MAP[i]) begin : g_d
      assert_digital_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        digital_commit |=> active_flat[i*DATA_W +: DATA_W] == $past(shadow_flat[i*DATA_W +: DATA_W]));
    end
  end
endmodule

bind sdc_shadow_commit sdc_shadow_commit_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PANEL_MAP(PANEL_MAP), .DIGITAL_MAP(DIGITAL_MAP)
) u_checker (
  .clk(clk), .rst_n(rst_n), .panel_evt(panel_evt), .digital_evt(digital_evt),
  .panel_go(panel_go), .digital_go(digital_go),
  .panel_arm(panel_arm), .digital_arm(digital_arm),
  .panel_commit(panel_commit), .digital_commit(digital_commit),
  .shadow_flat(shadow_flat), .active_flat(active_flat)
);

// File: tb/sdc_shadow_commit_bench.sv
module sdc_shadow_commit_bench;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          panel_evt = 1'b0;
  logic          digital_evt = 1'b0;
  logic [N*DW-1:0] active_flat;
  logic          panel_go;
  logic          digital_go;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_sh  [N];
  logic [DW-1:0] m_act [N];
  logic          m_pgo;
  logic          m_dgo;

  always #4 clk = ~clk;  // 125 MHz

  sdc_shadow_commit u_sdc_shadow_commit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .panel_evt(panel_evt), .digital_evt(digital_evt),
    .active_flat(active_flat), .panel_go(panel_go), .digital_go(digital_go)
  );

  // Register maps restated: panel owns 0..4, digital owns 0,1 and 5..7.
  function automatic bit on_panel(int i);   return i <= 4; endfunction
  function automatic bit on_digital(int i); return (i < 2) || (i >= 5); endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_sh[i]  = DW'((i + 1) * 37);
      m_act[i] = DW'((i + 1) * 37);
    end
    m_pgo = 1'b0;
    m_dgo = 1'b0;
  endtask

  task automatic check_all(string tag);
    checks++;
    for (int i = 0; i < N; i++) begin
      if (active_flat[i*DW +: DW] !== m_act[i]) begin
        errors++;
        $display("FAIL %s: active[%0d] = %h, expected %h", tag, i, active_flat[i*DW +: DW], m_act[i]);
      end
    end
    if (panel_go !== m_pgo || digital_go !== m_dgo) begin
      errors++;
      $display("FAIL %s: flags p=%b d=%b, expected p=%b d=%b", tag, panel_go, digital_go, m_pgo, m_dgo);
    end
  endtask

  // One clock cycle: drive at the falling edge, update the model at the rising edge, check at the next falling edge.
  task automatic step(bit we, int addr, logic [DW-1:0] data, bit pe, bit de, string tag);
    bit pc, dc;
    wr_en = we; wr_addr = AW'(addr); wr_data = data; panel_evt = pe; digital_evt = de;
    @(posedge clk);
    pc = pe && m_pgo;
    dc = de && m_dgo;
    for (int i = 0; i < N; i++)
      if ((pc && on_panel(i)) || (dc && on_digital(i))) m_act[i] = m_sh[i];
    if (we && addr < N) m_sh[addr] = data;
    if (pc) m_pgo = 1'b0; else if (we && addr == N && data[5]) m_pgo = 1'b1;
    if (dc) m_dgo = 1'b0; else if (we && addr == N && data[6]) m_dgo = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; panel_evt = 1'b0; digital_evt = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset state");

    // R2: shadow writes alone change nothing visible.
    for (int i = 0; i < N; i++) step(1, i, DW'(16'hA000 + i), 0, 0, "R2 shadow write");
    step(0, 0, '0, 0, 0, "R2 idle after writes");

    // R7: events with no armed flag.
    step(0, 0, '0, 1, 1, "R7 events while flags clear");

    // R3: 0 bits do not arm, each bit arms its own flag.
    step(1, N, 16'h0000, 0, 0, "R3 zero control write");
    step(1, N, 16'h0020, 0, 0, "R3 panel arm bit5");
    step(1, N, 16'h0040, 0, 0, "R3 digital arm bit6");
    step(1, N, 16'h0000, 0, 0, "R3 zero write keeps flags");

    // R4 and R6: panel commit, then arming in the cycle of the commit.
    step(0, 0, '0, 1, 0, "R4 R6 panel commit");
    step(1, N, 16'h0020, 0, 0, "R3 rearm panel");
    step(1, N, 16'h0020, 1, 0, "R6 clear beats arm");
    // R5: digital commit (still armed from before).
    step(0, 0, '0, 0, 1, "R5 R6 digital commit");

    // R10: writes above the control address are ignored.
    for (int a = N + 1; a < (1 << AW); a++) step(1, a, 16'hFFFF, 0, 0, "R10 out-of-range write");
    step(1, N, 16'h0060, 0, 0, "R3 arm both");
    step(0, 0, '0, 1, 1, "R10 R9 commit after ignored writes");

    // Sweep: arm pattern x event pattern x same-cycle write, R4 R5 R7 R8 R9.
    for (int it = 0; it < 32; it++) begin
      int arm = it & 3;
      int ev  = (it >> 2) & 3;
      bit wsame = it[4];
      int tgt = it % N;
      for (int i = 0; i < N; i++)
        step(1, i, DW'(it * 911 + i * 131 + 7), 0, 0, "R2 sweep load");
      step(1, N, DW'((arm & 1) << 5 | (arm & 2) << 5), 0, 0, "R3 sweep arm");
      step(wsame, tgt, DW'(16'h5A00 + it), ev[0], ev[1], "R4 R5 R7 R8 R9 sweep commit");
      // Drain: commit what remains so the same-cycle write is seen (R8).
      step(1, N, 16'h0060, 0, 0, "R3 sweep rearm");
      step(0, 0, '0, 1, 1, "R8 R9 sweep drain");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule